// File: doc/BRIEF.md
# DMA Transfer Setup Registers

This block holds the setup state for a peripheral DMA engine: a 14-bit transfer count, a direction bit, an enable bit and a 22-bit word address. Software loads the count together with the two control bits through a single 16-bit data write. Every such write also bumps the count once, which models the dummy transfer that the hardware performs when the count is loaded.

The DMA address is not taken from the data bus. It is captured from the CPU's own word address lines during a write to the address register, and the data bus is ignored for that write. Bus address line 14 picks the half: a high line fills the upper thirteen bits, and a low line fills bits 8 to 1. Bit 0 is always zero.

The transfer engine itself is not part of this block. The engine pulses a step input once per word moved. The block merges that step with the dummy increment, wraps the count modulo 2^14 and raises a terminal-count flag. Every interface here is a single-cycle register strobe with no back-pressure. A strobe is taken on the rising clock edge at which it is high.

Top module: `dma_xfer_regs`

## Requirements
- R1: While reset is held, the count, direction, enable, terminal-count flag and DMA address are all zero.
- R2: A count write (`cnt_wr` high) stores `wdata[13:0]` as the count base, `wdata[14]` as the direction and `wdata[15]` as the enable. The direction and enable are visible one cycle later.
- R3: A count write also increments the loaded value once. One cycle after the write, `xfer_count` equals `wdata[13:0] + 1`.
- R4: A `step` pulse with no count write increments the count by one. A `step` in the same cycle as a count write gives `wdata[13:0] + 1`, not `+ 2`.
- R5: The count wraps from 16383 to 0. `term_cnt` is updated only on an increment (a write or a step). It goes high when the incremented count is 0 and low when the incremented count is nonzero.
- R6: `rd_data` always shows the count in bits [13:0], with bits 15 and 14 reading as 1.
- R7: An address write with `bus_addr[14]` high loads DMA address bits [21:9] from `bus_addr[13:1]` and keeps bits [8:0].
- R8: An address write with `bus_addr[14]` low loads DMA address bits [8:1] from `bus_addr[8:1]`. It ignores `bus_addr[13:9]` and keeps bits [21:9].
- R9: DMA address bit 0 is always 0.
- R10: An address write leaves the count, direction, enable and flag untouched and ignores `wdata`. A count write leaves the DMA address untouched. Both writes may occur in the same cycle.
- R11: In a cycle with no count write and no step, the count, direction, enable and `term_cnt` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_wr | input | 1 | Count/control register write strobe |
| wdata | input | 16 | Write data for the count register |
| adr_wr | input | 1 | Address register write strobe |
| bus_addr | input | 14 ([14:1]) | CPU word address lines; bit 14 selects the half |
| step | input | 1 | One-word-moved pulse from the transfer engine |
| rd_data | output | 16 | Count register readback |
| xfer_count | output | 14 | Current transfer count |
| xfer_dir | output | 1 | Transfer direction bit |
| xfer_en | output | 1 | DMA enable bit |
| xfer_addr | output | 22 | DMA byte address, word aligned |
| term_cnt | output | 1 | Count reached zero on the last increment |

## Verification
Every piece of internal state drives an output directly. A wrong count, control bit, flag or address half therefore shows on the ports on the cycle right after the strobe that produced it.

Three kinds of error are the ones to watch for:
- A doubled increment when a step and a write coincide. This shows as a count that is off by one.
- A half-select decoded the wrong way. This shows as a clobbered address half.
- A flag updated on idle cycles. This shows as `term_cnt` changing without a strobe.

The scoreboard compares the whole output state after every driven cycle, so each such error is caught in the cycle it occurs.

// File: rtl/dma_xfer_regs_pkg.sv
package dma_xfer_regs_pkg;

  // Which part of the DMA address an address-register write targets
  typedef enum logic {
    ADR_HALF_LO = 1'b0,
    ADR_HALF_HI = 1'b1
  } adr_half_e;

  // Control bits carried alongside the count
  typedef struct packed {
    logic enable;
    logic dir;
  } xfer_ctl_t;

endpackage

// File: rtl/xfer_count_unit.sv
module xfer_count_unit #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             tc
);

  logic             bump;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] nxt;

  // Loading and stepping share one incrementer, so they merge into a single +1
  assign bump = load | step;
  assign base = load ? load_val : count;
  assign nxt  = base + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      tc    <= 1'b0;
    end else if (bump) begin
      count <= nxt;
      tc    <= (nxt == '0);
    end
  end

endmodule

// File: rtl/xfer_ctl_reg.sv
module xfer_ctl_reg
  import dma_xfer_regs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  xfer_ctl_t din,
  output xfer_ctl_t q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= din;
    end
  end

endmodule

// File: rtl/xfer_addr_unit.sv
module xfer_addr_unit
  import dma_xfer_regs_pkg::*;
#(
  parameter int DADDR_W = 22,
  parameter int ADR_SEL = 14,
  parameter int LO_TOP  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [ADR_SEL:1]   bus_addr,
  output logic [DADDR_W-1:0] addr
);

  localparam int HI_W = DADDR_W - 1 - LO_TOP;

  adr_half_e half;
  logic      wr_lo;
  logic      wr_hi;

  assign half  = adr_half_e'(bus_addr[ADR_SEL]);
  assign wr_lo = wr && (half == ADR_HALF_LO);
  assign wr_hi = wr && (half == ADR_HALF_HI);

  // Word alignment: the lowest bit is never stored
  assign addr[0] = 1'b0;

  for (genvar i = 1; i < DADDR_W; i++) begin : g_bit
    if (i <= LO_TOP) begin : g_lo
      // Low half: bus line i lands on address bit i
      always_ff @(posedge clk) begin
        if (!rst_n)     addr[i] <= 1'b0;
        else if (wr_lo) addr[i] <= bus_addr[i];
      end
    end else begin : g_hi
      // High half: bus line (i - LO_TOP) lands on address bit i
      always_ff @(posedge clk) begin
        if (!rst_n)     addr[i] <= 1'b0;
        else if (wr_hi) addr[i] <= bus_addr[i-LO_TOP];
      end
    end
  end

  if (HI_W >= ADR_SEL) begin : g_bad_cfg
    initial $error("high address field overlaps the half-select line");
  end

endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
  import dma_xfer_regs_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int DADDR_W = 22,
  parameter int ADR_SEL = 14,
  parameter int LO_TOP  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_wr,
  input  logic [CNT_W+1:0]   wdata,
  input  logic               adr_wr,
  input  logic [ADR_SEL:1]   bus_addr,
  input  logic               step,
  output logic [CNT_W+1:0]   rd_data,
  output logic [CNT_W-1:0]   xfer_count,
  output logic               xfer_dir,
  output logic               xfer_en,
  output logic [DADDR_W-1:0] xfer_addr,
  output logic               term_cnt
);

  localparam int DIR_BIT = CNT_W;
  localparam int EN_BIT  = CNT_W + 1;

  xfer_ctl_t ctl_in;
  xfer_ctl_t ctl_q;

  assign ctl_in.enable = wdata[EN_BIT];
  assign ctl_in.dir    = wdata[DIR_BIT];

  xfer_count_unit #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_wr),
    .load_val (wdata[CNT_W-1:0]),
    .step     (step),
    .count    (xfer_count),
    .tc       (term_cnt)
  );

  xfer_ctl_reg u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cnt_wr),
    .din   (ctl_in),
    .q     (ctl_q)
  );

  xfer_addr_unit #(
    .DADDR_W (DADDR_W),
    .ADR_SEL (ADR_SEL),
    .LO_TOP  (LO_TOP)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (adr_wr),
    .bus_addr (bus_addr),
    .addr     (xfer_addr)
  );

  assign xfer_dir = ctl_q.dir;
  assign xfer_en  = ctl_q.enable;

  // Readback: the two top bits read as 1, the count fills the rest
  assign rd_data = {2'b11, xfer_count};

endmodule

// File: rtl/dma_xfer_regs_chk.sv
module dma_xfer_regs_chk #(
  parameter int CNT_W   = 14,
  parameter int DADDR_W = 22,
  parameter int ADR_SEL = 14,
  parameter int LO_TOP  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cnt_wr,
  input logic [CNT_W+1:0]   wdata,
  input logic               adr_wr,
  input logic [ADR_SEL:1]   bus_addr,
  input logic               step,
  input logic [CNT_W+1:0]   rd_data,
  input logic [CNT_W-1:0]   xfer_count,
  input logic               xfer_dir,
  input logic               xfer_en,
  input logic [DADDR_W-1:0] xfer_addr,
  input logic               term_cnt
);

  localparam int HI_W = DADDR_W - 1 - LO_TOP;

  assert_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (xfer_en == $past(wdata[CNT_W+1])) && (xfer_dir == $past(wdata[CNT_W])));

  assert_dummy_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> xfer_count == CNT_W'($past(wdata[CNT_W-1:0]) + 1'b1));

  assert_step_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_wr) |=> xfer_count == CNT_W'($past(xfer_count) + 1'b1));

  assert_tc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step || cnt_wr) |=> term_cnt == (xfer_count == '0));

  assert_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[CNT_W+1:CNT_W] == 2'b11) && (rd_data[CNT_W-1:0] == xfer_count));

  assert_hi_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_wr && bus_addr[ADR_SEL]) |=>
      (xfer_addr[DADDR_W-1:LO_TOP+1] == $past(bus_addr[HI_W:1])) &&
      (xfer_addr[LO_TOP:0] == $past(xfer_addr[LO_TOP:0])));

  assert_lo_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_wr && !bus_addr[ADR_SEL]) |=>
      (xfer_addr[LO_TOP:1] == $past(bus_addr[LO_TOP:1])) &&
      (xfer_addr[DADDR_W-1:LO_TOP+1] == $past(xfer_addr[DADDR_W-1:LO_TOP+1])));

  assert_word_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_addr[0] == 1'b0);

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !adr_wr |=> $stable(xfer_addr));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !step) |=> $stable(xfer_count) && $stable(xfer_dir) &&
                           $stable(xfer_en) && $stable(term_cnt));

endmodule

bind dma_xfer_regs dma_xfer_regs_chk #(
  .CNT_W   (CNT_W),
  .DADDR_W (DADDR_W),
  .ADR_SEL (ADR_SEL),
  .LO_TOP  (LO_TOP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_wr     (cnt_wr),
  .wdata      (wdata),
  .adr_wr     (adr_wr),
  .bus_addr   (bus_addr),
  .step       (step),
  .rd_data    (rd_data),
  .xfer_count (xfer_count),
  .xfer_dir   (xfer_dir),
  .xfer_en    (xfer_en),
  .xfer_addr  (xfer_addr),
  .term_cnt   (term_cnt)
);

// File: tb/tb_dma_xfer_regs.sv
module tb_dma_xfer_regs;

  typedef struct packed {
    logic [15:0] rd;
    logic [13:0] cnt;
    logic        dir;
    logic        en;
    logic        tc;
    logic [21:0] addr;
  } snap_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [15:0] wdata = '0;
  logic        adr_wr = 1'b0;
  logic [14:1] bus_addr = '0;
  logic        step = 1'b0;
  logic [15:0] rd_data;
  logic [13:0] xfer_count;
  logic        xfer_dir;
  logic        xfer_en;
  logic [21:0] xfer_addr;
  logic        term_cnt;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  snap_t exp_q[$];
  string tag_q[$];

  // Reference model state
  logic [13:0] m_cnt = '0;
  logic        m_dir = 1'b0;
  logic        m_en = 1'b0;
  logic        m_tc = 1'b0;
  logic [21:0] m_addr = '0;

  always #5 clk = ~clk;

  dma_xfer_regs dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_wr     (cnt_wr),
    .wdata      (wdata),
    .adr_wr     (adr_wr),
    .bus_addr   (bus_addr),
    .step       (step),
    .rd_data    (rd_data),
    .xfer_count (xfer_count),
    .xfer_dir   (xfer_dir),
    .xfer_en    (xfer_en),
    .xfer_addr  (xfer_addr),
    .term_cnt   (term_cnt)
  );

  function automatic snap_t actual();
    snap_t s;
    s.rd = rd_data; s.cnt = xfer_count; s.dir = xfer_dir;
    s.en = xfer_en; s.tc = term_cnt; s.addr = xfer_addr;
    return s;
  endfunction

  function automatic snap_t model();
    snap_t s;
    s.rd = {2'b11, m_cnt}; s.cnt = m_cnt; s.dir = m_dir;
    s.en = m_en; s.tc = m_tc; s.addr = m_addr;
    return s;
  endfunction

  task automatic compare(input snap_t act, input snap_t exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual rd=%h cnt=%h dir=%b en=%b tc=%b addr=%h expected rd=%h cnt=%h dir=%b en=%b tc=%b addr=%h",
               tag, act.rd, act.cnt, act.dir, act.en, act.tc, act.addr,
               exp.rd, exp.cnt, exp.dir, exp.en, exp.tc, exp.addr);
    end
  endtask

  // Driver: one call is one clock cycle of stimulus plus its expected result
  task automatic drive(input logic cw, input logic [15:0] wd, input logic aw,
                       input logic [14:1] ba, input logic st, input string tag);
    @(negedge clk);
    cnt_wr = cw; wdata = wd; adr_wr = aw; bus_addr = ba; step = st;
    if (cw || st) begin
      m_cnt = (cw ? wd[13:0] : m_cnt) + 14'd1;
      m_tc  = (m_cnt == 14'd0);
    end
    if (cw) begin
      m_dir = wd[14];
      m_en  = wd[15];
    end
    if (aw) begin
      if (ba[14]) m_addr[21:9] = ba[13:1];
      else        m_addr[8:1]  = ba[8:1];
    end
    exp_q.push_back(model());
    tag_q.push_back(tag);
  endtask

  // Monitor: compare just after each edge that consumed a driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        snap_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compare(actual(), e, t);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(actual(), '{rd: 16'hC000, cnt: '0, dir: 1'b0, en: 1'b0, tc: 1'b0, addr: '0}, "R1 reset");
    rst_n = 1'b1;

    drive(1, 16'h8005, 0, '0, 0, "R2 R3 load 5 enable");
    drive(0, 16'hFFFF, 0, '0, 0, "R11 idle hold, R6 readback");
    drive(1, 16'h7FFF, 0, '0, 0, "R5 wrap to zero sets tc, R2 dir");
    drive(0, 16'h0000, 0, '0, 0, "R11 tc held on idle");
    drive(0, 16'h0000, 0, '0, 1, "R4 step clears tc");
    drive(1, 16'h0010, 0, '0, 1, "R4 step merged with write");
    drive(0, 16'h0000, 0, '0, 1, "R4 step");
    drive(0, 16'h0000, 0, '0, 1, "R4 step");
    drive(1, 16'hBFFE, 0, '0, 0, "R3 load near top");
    drive(0, 16'h0000, 0, '0, 1, "R5 step wraps, tc high");
    drive(0, 16'h0000, 0, '0, 1, "R5 step after zero, tc low");
    drive(0, 16'h1234, 1, {1'b1, 13'h1ABC}, 0, "R7 high half, R10 wdata ignored");
    drive(0, 16'h0000, 1, {1'b0, 13'h1FA5}, 0, "R8 low half keeps high");
    drive(0, 16'h0000, 1, {1'b1, 13'h0421}, 0, "R7 high half keeps low");
    drive(0, 16'h0000, 1, {1'b0, 13'h1E00}, 0, "R8 upper bus lines ignored");
    drive(1, 16'h4321, 1, {1'b1, 13'h1FFF}, 0, "R10 both writes together");
    drive(0, 16'h0000, 1, {1'b0, 13'h1FFF}, 1, "R9 word aligned, R10 step with addr");
    drive(0, 16'h0000, 0, '0, 0, "R11 final idle");

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual run still active expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule